// File: doc/BRIEF.md
# Test Cube Compatibility Matcher

This block decides whether one deterministic test cube can be produced by one pattern of pseudo-random generator output, given the tap-to-chain connections still allowed in the current configuration. Each request supplies three things. The first is the bit stream that each generator tap produces over one scan load. The second is the cube, split into one value vector and one care vector per scan chain. The third is a flag that marks the last cube tried against the current pattern. The block keeps, for every chain, a set of taps that may still drive that chain. The block accepts a cube when every chain has at least one allowed tap whose stream agrees with the chain's care bits. When it accepts a cube, it trims each chain's set down to the taps that agree.

The block works through one chain per clock cycle, so the latency is fixed and depends only on the number of chains. It also counts consecutive patterns in which no cube matched. A configuration-end flag goes high once that count passes the allowed number of skipped patterns. A configuration-start pulse reopens every tap to every chain and clears the counter.

Top module: `cube_matcher`

## Requirements
- R1: After reset, and in the cycle after a `cfgStart` pulse, every bit of `tapMask` is 1, `cfgEnd` is 0, `resValid` is 0 and `reqReady` is 1. A `cfgStart` pulse also abandons any request in progress.
- R2: A request is taken at a rising edge where `reqValid` and `reqReady` are both 1. From then on `reqReady` stays 0. `resValid` goes to 1 after the NUM_CHAINS-th rising edge that follows the accepting edge, and it stays 1 for exactly one cycle.
- R3: Chain j's cube value and care bits sit at bits [j*CHAIN_LEN +: CHAIN_LEN] of `cubeValue` and `cubeCare`. Tap k's stream sits at bits [k*CHAIN_LEN +: CHAIN_LEN] of `tapStreams`. A care bit of 1 marks a specified position. Tap k is compatible with chain j when the tap's bit equals the cube's bit at every position where the care bit is 1.
- R4: `resMatch` is 1 exactly when every chain has at least one tap that is both allowed in `tapMask` and compatible with that chain.
- R5: On a match, bit j*NUM_TAPS+k of `tapMask` is cleared whenever tap k is incompatible with chain j. Every other bit keeps its value. The new mask is visible in the cycle where `resValid` is 1.
- R6: When there is no match, `tapMask` is left unchanged.
- R7: A cube with no care bits always matches and leaves `tapMask` unchanged.
- R8: A pattern closes with each request that has `lastCube` = 1. When SKIP_LIMIT+1 patterns in a row close without any match, `cfgEnd` goes to 1 in the cycle after `resValid`. A pattern that contains a match sets the run count back to zero, which lowers `cfgEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | Begin a new configuration: all taps allowed, counter cleared |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| tapStreams | input | NUM_TAPS*CHAIN_LEN | One scan load of output bits per tap |
| cubeValue | input | NUM_CHAINS*CHAIN_LEN | Cube bit values, per chain |
| cubeCare | input | NUM_CHAINS*CHAIN_LEN | Cube care bits, per chain |
| lastCube | input | 1 | This request closes the current pattern |
| resValid | output | 1 | Result present (one cycle) |
| resMatch | output | 1 | Cube embeds under the allowed connections |
| tapMask | output | NUM_CHAINS*NUM_TAPS | Allowed taps per chain |
| cfgEnd | output | 1 | Run of unmatched patterns has exceeded the limit |

## Verification
Some properties are checked on every cycle by assertions. The allowed-tap sets only ever lose bits, except on a configuration start. No chain is ever left with an empty set. A miss leaves the sets exactly as they were. The result strobe lasts one cycle. The configuration-end flag can only rise just after a result.

Other behaviour can only be shown by the bench's scenarios. These include which taps survive for a given cube, a match hidden by don't-care bits, the exact latency, and the count of unmatched patterns that raises and later clears the end flag. The bench drives directed cases and random cases, and compares each result against a model of the requirements.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DONE} cmState_t;

  typedef struct packed {
    logic clear;      // configuration start
    logic load;       // request accepted
    logic eval;       // evaluate the indexed chain
    logic lastChain;  // evaluation of the final chain
    logic finish;     // result cycle
  } cmStrobe_t;
endpackage

// File: rtl/cm_ctrl.sv
module cm_ctrl
  import cm_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  localparam int IDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgStart,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             resValid,
  output logic [IDX_W-1:0] chainIdx,
  output cmStrobe_t        strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHAINS - 1);

  cmState_t state;

  always_ff @(posedge clk) begin
    if (!rstN || cfgStart) begin
      state    <= S_IDLE;
      chainIdx <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          state    <= S_EVAL;
          chainIdx <= '0;
        end
        S_EVAL: if (chainIdx == LAST_IDX) state <= S_DONE;
                else chainIdx <= chainIdx + 1'b1;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);
  assign resValid = (state == S_DONE);

  always_comb begin
    strobe.clear     = cfgStart;
    strobe.load      = (state == S_IDLE) && reqValid && !cfgStart;
    strobe.eval      = (state == S_EVAL) && !cfgStart;
    strobe.lastChain = strobe.eval && (chainIdx == LAST_IDX);
    strobe.finish    = (state == S_DONE) && !cfgStart;
  end

  // R2: once a request is taken the block reports busy
  a_r2_busy_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !reqReady);
  // R2: result strobe lasts one cycle
  a_r2_result_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
endmodule

// File: rtl/cm_datapath.sv
module cm_datapath
  import cm_pkg::*;
#(
  parameter int NUM_TAPS   = 8,
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 8,
  parameter int SKIP_LIMIT = 2,
  localparam int IDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
  localparam int RUN_W = $clog2(SKIP_LIMIT + 2) + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cmStrobe_t                        strobe,
  input  logic [IDX_W-1:0]                 chainIdx,
  input  logic [NUM_TAPS*CHAIN_LEN-1:0]    tapStreams,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0]  cubeValue,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0]  cubeCare,
  input  logic                             lastCube,
  output logic                             resMatch,
  output logic [NUM_CHAINS*NUM_TAPS-1:0]   tapMask,
  output logic                             cfgEnd
);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(SKIP_LIMIT + 1);

  logic [NUM_TAPS-1:0][CHAIN_LEN-1:0]   tapReg;
  logic [NUM_CHAINS-1:0][CHAIN_LEN-1:0] valReg, careReg;
  logic [NUM_CHAINS-1:0][NUM_TAPS-1:0]  maskReg, workMask, mergedMask;
  logic                                 lastReg, allOk, patHit;
  logic [RUN_W-1:0]                     runCnt;
  logic [NUM_TAPS-1:0]                  compatVec, narrowSel;
  logic                                 chainOk;

  // One comparator per tap against the chain under evaluation
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign compatVec[k] = ~|((tapReg[k] ^ valReg[chainIdx]) & careReg[chainIdx]);
  end

  assign narrowSel = maskReg[chainIdx] & compatVec;
  assign chainOk   = |narrowSel;

  always_comb begin
    mergedMask = workMask;
    mergedMask[chainIdx] = narrowSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      maskReg  <= '1;
      workMask <= '1;
      allOk    <= 1'b0;
      resMatch <= 1'b0;
      runCnt   <= '0;
      patHit   <= 1'b0;
      lastReg  <= 1'b0;
    end else begin
      if (strobe.load) begin
        tapReg  <= tapStreams;
        valReg  <= cubeValue;
        careReg <= cubeCare;
        lastReg <= lastCube;
        allOk   <= 1'b1;
      end
      if (strobe.eval) begin
        workMask[chainIdx] <= narrowSel;
        allOk              <= allOk & chainOk;
      end
      if (strobe.lastChain) begin
        resMatch <= allOk & chainOk;
        if (allOk && chainOk) maskReg <= mergedMask;
      end
      if (strobe.finish) begin
        if (lastReg) begin
          patHit <= 1'b0;
          if (patHit || resMatch)   runCnt <= '0;
          else if (runCnt < RUN_LIMIT) runCnt <= runCnt + 1'b1;
        end else begin
          patHit <= patHit | resMatch;
        end
      end
    end
  end

  assign tapMask = maskReg;
  assign cfgEnd  = (runCnt == RUN_LIMIT);

  // R5: outside a configuration start the allowed sets never gain a tap
  a_r5_mask_only_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> ((tapMask & ~$past(tapMask)) == '0));
  // R6: a miss leaves the allowed sets untouched
  a_r6_miss_holds_mask: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !resMatch) |-> (tapMask == $past(tapMask)));
  // R1: configuration start reopens every tap
  a_r1_start_reopens: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (&tapMask && !cfgEnd));
  // R8: end flag only rises right after a result
  a_r8_end_after_result: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgEnd) |-> $past(strobe.finish));
  // R4: a chain never loses its last allowed tap
  for (genvar j = 0; j < NUM_CHAINS; j++) begin : g_chk
    a_r4_chain_nonempty: assert property (@(posedge clk) disable iff (!rstN)
      |maskReg[j]);
  end
endmodule

// File: rtl/cube_matcher.sv
module cube_matcher
  import cm_pkg::*;
#(
  parameter int NUM_TAPS   = 8,
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 8,
  parameter int SKIP_LIMIT = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgStart,
  input  logic                            reqValid,
  output logic                            reqReady,
  input  logic [NUM_TAPS*CHAIN_LEN-1:0]   tapStreams,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0] cubeValue,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0] cubeCare,
  input  logic                            lastCube,
  output logic                            resValid,
  output logic                            resMatch,
  output logic [NUM_CHAINS*NUM_TAPS-1:0]  tapMask,
  output logic                            cfgEnd
);
  localparam int IDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;

  cmStrobe_t        strobe;
  logic [IDX_W-1:0] chainIdx;

  cm_ctrl #(.NUM_CHAINS(NUM_CHAINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .reqValid(reqValid),
    .reqReady(reqReady), .resValid(resValid), .chainIdx(chainIdx), .strobe(strobe)
  );

  cm_datapath #(
    .NUM_TAPS(NUM_TAPS), .NUM_CHAINS(NUM_CHAINS),
    .CHAIN_LEN(CHAIN_LEN), .SKIP_LIMIT(SKIP_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chainIdx(chainIdx),
    .tapStreams(tapStreams), .cubeValue(cubeValue), .cubeCare(cubeCare),
    .lastCube(lastCube), .resMatch(resMatch), .tapMask(tapMask), .cfgEnd(cfgEnd)
  );
endmodule

// File: tb/cube_matcher_bench.sv
module cube_matcher_bench;
  localparam int L = 8, M = 4, W = 8, SKIP = 2;

  logic clk = 1'b0, rstN = 1'b0, cfgStart = 1'b0, reqValid = 1'b0, lastCube = 1'b0;
  logic [L*W-1:0] tapStreams = '0;
  logic [M*W-1:0] cubeValue = '0, cubeCare = '0;
  logic reqReady, resValid, resMatch, cfgEnd;
  logic [M*L-1:0] tapMask;

  always #10 clk = ~clk;  // 50 MHz

  cube_matcher #(.NUM_TAPS(L), .NUM_CHAINS(M), .CHAIN_LEN(W), .SKIP_LIMIT(SKIP)) u_cube_matcher (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .reqValid(reqValid), .reqReady(reqReady),
    .tapStreams(tapStreams), .cubeValue(cubeValue), .cubeCare(cubeCare), .lastCube(lastCube),
    .resValid(resValid), .resMatch(resMatch), .tapMask(tapMask), .cfgEnd(cfgEnd)
  );

  int nChecks = 0, nFails = 0;
  logic [M*L-1:0] mdlMask;
  int mdlRun;
  bit mdlHit;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  function automatic bit tapOk(input logic [L*W-1:0] t, input logic [M*W-1:0] v,
                               input logic [M*W-1:0] c, input int j, input int k);
    return ((t[k*W +: W] ^ v[j*W +: W]) & c[j*W +: W]) == '0;
  endfunction

  task automatic resetModel();
    mdlMask = '1; mdlRun = 0; mdlHit = 0;
  endtask

  task automatic doCfgStart();
    @(negedge clk); cfgStart = 1'b1;
    @(posedge clk); @(negedge clk); cfgStart = 1'b0;
    resetModel();
    check(&tapMask && !cfgEnd && reqReady && !resValid, "R1 cfgStart", {tapMask, cfgEnd}, {{(M*L){1'b1}}, 1'b0});
  endtask

  task automatic runReq(input logic [L*W-1:0] t, input logic [M*W-1:0] v,
                        input logic [M*W-1:0] c, input bit last);
    logic [M*L-1:0] sel;
    bit ok = 1'b1;
    bit lat = 1'b1;
    for (int j = 0; j < M; j++) begin
      for (int k = 0; k < L; k++) sel[j*L+k] = mdlMask[j*L+k] & tapOk(t, v, c, j, k);
      if (sel[j*L +: L] == '0) ok = 1'b0;
    end
    if (ok) mdlMask = sel;
    if (last) begin
      if (mdlHit || ok) mdlRun = 0; else if (mdlRun < SKIP + 1) mdlRun++;
      mdlHit = 0;
    end else mdlHit = mdlHit | ok;

    @(negedge clk);
    tapStreams = t; cubeValue = v; cubeCare = c; lastCube = last; reqValid = 1'b1;
    check(reqReady === 1'b1, "R2 ready before request", {63'd0, reqReady}, 64'd1);
    @(posedge clk); @(negedge clk); reqValid = 1'b0;
    for (int n = 1; n <= M; n++) begin
      @(posedge clk); @(negedge clk);
      if (n < M && (resValid || reqReady)) lat = 1'b0;
    end
    check(lat && resValid === 1'b1, "R2 latency", {63'd0, resValid}, 64'd1);
    check(resMatch === ok, "R4 match flag", {63'd0, resMatch}, {63'd0, ok});
    check(tapMask === mdlMask, ok ? "R5 narrowed mask" : "R6 mask held", tapMask, mdlMask);
    @(posedge clk); @(negedge clk);
    check(!resValid && cfgEnd === (mdlRun == SKIP + 1), "R8 cfgEnd", {63'd0, cfgEnd}, {63'd0, mdlRun == SKIP + 1});
  endtask

  function automatic logic [L*W-1:0] randTaps();
    logic [L*W-1:0] t;
    for (int k = 0; k < L; k++) t[k*W +: W] = W'($urandom);
    return t;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [L*W-1:0] t;
    logic [M*W-1:0] v, c;
    void'($urandom(32'd4242));
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    check(&tapMask && !cfgEnd && reqReady && !resValid, "R1 reset state", {tapMask, cfgEnd}, {{(M*L){1'b1}}, 1'b0});

    // R7: no care bits
    t = randTaps();
    runReq(t, M*W'($urandom), '0, 1'b0);

    // R3 R5: every chain copies tap 3 with all bits cared
    t = '0;
    for (int k = 0; k < L; k++) t[k*W +: W] = W'(8'h11 * k + 1);
    v = '0;
    for (int j = 0; j < M; j++) v[j*W +: W] = t[3*W +: W];
    runReq(t, v, '1, 1'b1);

    // R3: don't-care hides a mismatch; only masked bits differ from tap 3
    v = '0;
    for (int j = 0; j < M; j++) v[j*W +: W] = t[3*W +: W] ^ 8'hF0;
    c = '0;
    for (int j = 0; j < M; j++) c[j*W +: W] = 8'h0F;
    runReq(t, v, c, 1'b1);

    // R6 R8: repeated misses close patterns until the end flag rises
    for (int p = 0; p < SKIP + 2; p++) begin
      t = '0;
      v = '0; v[0 +: W] = 8'h01;
      c = '0; c[0 +: W] = 8'hFF;
      runReq(t, v, c, 1'b0);
      runReq(t, v, c, 1'b1);
    end
    // R8: a matching pattern clears the run
    runReq(randTaps(), '0, '0, 1'b1);

    // R1: start again, then random traffic
    doCfgStart();
    for (int r = 0; r < 150; r++) begin
      t = randTaps();
      for (int j = 0; j < M; j++) begin
        int k = int'($urandom % L);
        v[j*W +: W] = t[k*W +: W];
        if ($urandom % 4 == 0) v[j*W +: W] = W'($urandom);
        c[j*W +: W] = W'($urandom) & W'($urandom);
      end
      runReq(t, v, c, ($urandom % 2) == 1);
      if (r % 40 == 39) doCfgStart();
    end

    // R1: cfgStart abandons a request in flight
    @(negedge clk); reqValid = 1'b1; cubeCare = '0;
    @(posedge clk); @(negedge clk); reqValid = 1'b0;
    @(posedge clk); @(negedge clk); cfgStart = 1'b1;
    @(posedge clk); @(negedge clk); cfgStart = 1'b0;
    resetModel();
    check(reqReady && !resValid, "R1 abort in flight", {63'd0, reqReady}, 64'd1);
    repeat (M + 2) begin
      @(posedge clk); @(negedge clk);
      check(!resValid, "R1 no result after abort", {63'd0, resValid}, 64'd0);
    end
    finishRun();
  end
endmodule